// File: doc/BRIEF.md
# Compare Timer Core

This block is a 16-bit up-counting timer with a compare register. It has two count sources. In time mode it advances on a one-cycle tick enable that a separate prescaler or filter stage supplies. In pulse mode it advances on each inactive-to-active transition of one of four external inputs. Software chooses the input and its active level. Each input is assumed to be filtered already and synchronous to the system clock.

When the counter holds the compare value and receives one more count, the block does three things. It sets a sticky compare flag, it drives a one-cycle trigger pulse, and it either restarts the counter at zero or lets it keep running. The interrupt and the DMA request are the flag gated by their own enable bits. Software reaches the block through a small register bus. Reads are registered, and the counter is read through a snapshot that software takes by writing the count register.

Top module: `cmptmr_core`

## Requirements
- R1: After reset, all registers read 0 and `irq`, `trigger` and `dma_req` are low.
- R2: In time mode (control bit 1 = 0), with the run bit (control bit 0) set, the counter adds 1 on each clock edge where `time_tick` is high. The counter starts from zero.
- R3: The compare flag (control bit 8) sets on a count taken while the counter equals the compare register (address 1). `trigger` is high for exactly the cycle after that edge. The period is therefore compare+1 counts.
- R4: With the free-run bit (control bit 2) clear, the counter becomes 0 on the count that sets the flag.
- R5: With the free-run bit set, the counter continues past the compare value and wraps from 0xFFFF to 0.
- R6: Writing control with bit 8 = 1 clears the flag, and writing bit 8 = 0 leaves it unchanged. If a set and a clear happen on the same edge, the flag stays set.
- R7: While the run bit is clear, the counter is held at 0 and no count is taken.
- R8: In pulse mode (control bit 1 = 1), control bits 5:4 select `pulse_in`, and control bit 3 marks the input active-low. Each inactive-to-active transition of the selected input adds one count. Other inputs and `time_tick` are ignored. An input that is already active when the timer starts is not counted.
- R9: The mode, input-select and polarity fields change only on a write made while the run bit is clear. At other times the write keeps their old values.
- R10: `irq` is the flag ANDed with control bit 6, and `dma_req` is the flag ANDed with control bit 7.
- R11: A write to address 2 copies the live counter into a snapshot, and a read of address 2 returns that snapshot. `rsp_rdata` carries the addressed register one cycle after a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register address: 0 control, 1 compare, 2 count |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Read data, registered |
| time_tick | input | 1 | One-cycle count enable from the prescaler |
| pulse_in | input | 4 | External pulse inputs |
| irq | output | 1 | Interrupt request |
| trigger | output | 1 | One-cycle pulse when the flag sets |
| dma_req | output | 1 | DMA request |

## Verification
A count enable seen at a clock edge changes the counter, the flag and `trigger` at that same edge. The bench raises `time_tick` or a pulse input at a falling edge and checks `trigger` and `irq` at the next falling edge. It then checks that `trigger` has dropped one falling edge later. Register writes take effect at the rising edge inside the write task, and read data appears at the edge that completes the read. The bench reads `rsp_rdata` at the falling edge that follows, and keeps `time_tick` low during bus accesses so the counter stays at a known value.

// File: rtl/cmptmr_pkg.sv
package cmptmr_pkg;

  localparam int N_IN  = 4;
  localparam int SEL_W = $clog2(N_IN);

  typedef enum logic [1:0] {
    ADR_CTRL = 2'd0,
    ADR_CMP  = 2'd1,
    ADR_CNT  = 2'd2
  } reg_addr_e;

  // bit 0 run, 1 mode, 2 free_run, 3 pol, 5:4 sel, 6 irq_en, 7 dma_en
  typedef struct packed {
    logic             dma_en;
    logic             irq_en;
    logic [SEL_W-1:0] sel;
    logic             pol;
    logic             free_run;
    logic             mode;
    logic             run;
  } ctrl_t;

  localparam int CTRL_W   = $bits(ctrl_t);
  localparam int FLAG_BIT = CTRL_W;

  function automatic logic polarize(input logic level, input logic active_low);
    return level ^ active_low;
  endfunction

  // Source fields are frozen while the timer runs.
  function automatic ctrl_t merge_ctrl(input ctrl_t cur, input ctrl_t req);
    ctrl_t res;
    res = req;
    if (cur.run) begin
      res.mode = cur.mode;
      res.sel  = cur.sel;
      res.pol  = cur.pol;
    end
    return res;
  endfunction

endpackage

// File: rtl/cmptmr_source.sv
module cmptmr_source
  import cmptmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             mode,
  input  logic             pol,
  input  logic [SEL_W-1:0] sel,
  input  logic             time_tick,
  input  logic [N_IN-1:0]  pulse_in,
  output logic             count_en,
  output logic             pulse_edge
);

  logic [N_IN-1:0] active_vec;
  logic            active;
  logic            prev_q;

  for (genvar i = 0; i < N_IN; i++) begin : g_pol
    assign active_vec[i] = polarize(pulse_in[i], pol);
  end

  assign active = active_vec[sel];

  // Held at 1 while stopped, so an input already active at start is not counted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= run ? active : 1'b1;
  end

  assign pulse_edge = run & active & ~prev_q;
  assign count_en   = mode ? pulse_edge : time_tick;

endmodule

// File: rtl/cmptmr_counter.sv
module cmptmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             free_run,
  input  logic             count_en,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt_q,
  output logic             hit
);

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] cur,
                                            input logic             matched,
                                            input logic             keep_going);
    if (matched && !keep_going) return '0;
    return cur + CNT_W'(1);
  endfunction

  logic matched;
  assign matched = (cnt_q == cmp);
  assign hit     = run & count_en & matched;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (count_en) cnt_q <= step(cnt_q, matched, free_run);
  end

endmodule

// File: rtl/cmptmr_regs.sv
module cmptmr_regs
  import cmptmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              hit,
  input  logic [CNT_W-1:0]  cnt_q,
  output ctrl_t             ctrl_q,
  output logic [CNT_W-1:0]  cmp_q,
  output logic              flag_q,
  output logic              flag_clr,
  output logic              trigger_q
);

  logic       wr_ctrl, wr_cmp, wr_cnt, rd_req;
  ctrl_t      ctrl_req, ctrl_d;
  logic [CNT_W-1:0] snap_q;
  logic       unused_wdata;

  assign wr_ctrl  = req_valid & req_write & (req_addr == ADR_CTRL);
  assign wr_cmp   = req_valid & req_write & (req_addr == ADR_CMP);
  assign wr_cnt   = req_valid & req_write & (req_addr == ADR_CNT);
  assign rd_req   = req_valid & ~req_write;
  assign ctrl_req = ctrl_t'(req_wdata[CTRL_W-1:0]);
  assign flag_clr = wr_ctrl & req_wdata[FLAG_BIT];
  assign unused_wdata = ^req_wdata;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = merge_ctrl(ctrl_q, ctrl_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      cmp_q     <= '0;
      snap_q    <= '0;
      flag_q    <= 1'b0;
      trigger_q <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_d;
      trigger_q <= hit;
      if (wr_cmp) cmp_q  <= req_wdata[CNT_W-1:0];
      if (wr_cnt) snap_q <= cnt_q;
      if (hit)           flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_rdata <= '0;
    else if (rd_req) begin
      case (req_addr)
        ADR_CTRL: rsp_rdata <= DATA_W'({flag_q, ctrl_q});
        ADR_CMP:  rsp_rdata <= DATA_W'(cmp_q);
        ADR_CNT:  rsp_rdata <= DATA_W'(snap_q);
        default:  rsp_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/cmptmr_core.sv
module cmptmr_core
  import cmptmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              time_tick,
  input  logic [N_IN-1:0]   pulse_in,
  output logic              irq,
  output logic              trigger,
  output logic              dma_req
);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q, flag_clr, hit, count_en, pulse_edge;
  logic             run, free_run;
  logic [SEL_W+1:0] src_cfg;

  assign run      = ctrl_q.run;
  assign free_run = ctrl_q.free_run;
  assign src_cfg  = {ctrl_q.mode, ctrl_q.pol, ctrl_q.sel};

  cmptmr_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .hit(hit), .cnt_q(cnt_q),
    .ctrl_q(ctrl_q), .cmp_q(cmp_q), .flag_q(flag_q),
    .flag_clr(flag_clr), .trigger_q(trigger)
  );

  cmptmr_source u_source (
    .clk(clk), .rst_n(rst_n), .run(run),
    .mode(ctrl_q.mode), .pol(ctrl_q.pol), .sel(ctrl_q.sel),
    .time_tick(time_tick), .pulse_in(pulse_in),
    .count_en(count_en), .pulse_edge(pulse_edge)
  );

  cmptmr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .run(run), .free_run(free_run),
    .count_en(count_en), .cmp(cmp_q), .cnt_q(cnt_q), .hit(hit)
  );

  assign irq     = flag_q & ctrl_q.irq_en;
  assign dma_req = flag_q & ctrl_q.dma_en;

endmodule

// File: rtl/cmptmr_core_chk.sv
module cmptmr_core_chk #(
  parameter int CNT_W = 16,
  parameter int CFG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             free_run,
  input logic             hit,
  input logic             flag_q,
  input logic             flag_clr,
  input logic             trigger,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CFG_W-1:0] src_cfg
);

  AST_TRIG_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |-> flag_q); // R3

  AST_FLAG_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(hit)); // R3

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !free_run) |=> (cnt_q == '0)); // R4

  AST_STOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0)); // R7

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(src_cfg)); // R9

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q); // R6

endmodule

bind cmptmr_core cmptmr_core_chk #(.CNT_W(CNT_W), .CFG_W(cmptmr_pkg::SEL_W + 2)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .free_run(free_run), .hit(hit),
  .flag_q(flag_q), .flag_clr(flag_clr), .trigger(trigger),
  .cnt_q(cnt_q), .src_cfg(src_cfg)
);

// File: tb/test_cmptmr_core.sv
`timescale 1ns/1ps
module test_cmptmr_core;

  localparam int CNT_W  = 16;
  localparam int DATA_W = 32;
  localparam logic [1:0] A_CTRL = 2'd0, A_CMP = 2'd1, A_CNT = 2'd2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]        req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic [DATA_W-1:0] rsp_rdata;
  logic              time_tick = 1'b0;
  logic [3:0]        pulse_in = '0;
  logic              irq, trigger, dma_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cmptmr_core #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_cmptmr_core (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .time_tick(time_tick), .pulse_in(pulse_in),
    .irq(irq), .trigger(trigger), .dma_req(dma_req)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] cw(input logic run, input logic mode, input logic free,
                                     input logic pol, input logic [1:0] sel,
                                     input logic ie, input logic de, input logic clr);
    return {23'd0, clr, de, ie, sel, pol, free, mode, run};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    v = rsp_rdata;
  endtask

  task automatic rd_count(output logic [31:0] v);
    wr(A_CNT, 32'd0);
    rd(A_CNT, v);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    time_tick = 1'b1;
    repeat (n) @(negedge clk);
    time_tick = 1'b0;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    pulse_in[idx] = ~pulse_in[idx];
    @(negedge clk);
    pulse_in[idx] = ~pulse_in[idx];
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 trigger", {31'd0, trigger}, 0);
    check("R1 dma", {31'd0, dma_req}, 0);
    rd(A_CTRL, v); check("R1 ctrl", v, 0);
    rd(A_CMP, v);  check("R1 cmp", v, 0);
    rd_count(v);   check("R1 count", v, 0);

    // R2 R3 R4 R5 R10: sweep compare value and restart mode
    for (int f = 0; f < 2; f++) begin
      for (int c = 0; c < 7; c++) begin
        wr(A_CTRL, cw(0,0,0,0,0,0,0,1));
        wr(A_CMP, c);
        wr(A_CTRL, cw(1,0,f[0],0,0,1,0,0));
        if (c > 0) ticks(c);
        rd_count(v); check("R2 count before match", v, c);
        check("R10 irq low before match", {31'd0, irq}, 0);
        ticks(1);
        check("R3 trigger on match count", {31'd0, trigger}, 1);
        check("R10 irq follows flag", {31'd0, irq}, 1);
        @(negedge clk);
        check("R3 trigger one cycle", {31'd0, trigger}, 0);
        rd_count(v);
        if (f == 0) check("R4 restart at zero", v, 0);
        else        check("R5 continue past compare", v, c + 1);
        if (f == 0) begin
          wr(A_CTRL, cw(1,0,0,0,0,1,0,1));
          check("R6 clear drops irq", {31'd0, irq}, 0);
          if (c > 0) ticks(c);
          check("R3 no trigger early", {31'd0, trigger}, 0);
          ticks(1);
          check("R3 period compare+1", {31'd0, trigger}, 1);
        end
      end
    end

    // R5: wrap at overflow in free-run
    wr(A_CTRL, cw(0,0,0,0,0,0,0,1));
    wr(A_CMP, 5);
    wr(A_CTRL, cw(1,0,1,0,0,0,0,0));
    ticks(65535);
    rd_count(v); check("R5 reaches max", v, 32'hFFFF);
    ticks(1);
    rd_count(v); check("R5 wraps to zero", v, 0);

    // R6: write 0 to flag keeps it, set wins over clear
    rd(A_CTRL, v); check("R6 flag set", v[8], 1);
    wr(A_CTRL, cw(1,0,1,0,0,0,0,0));
    rd(A_CTRL, v); check("R6 zero write keeps flag", v[8], 1);
    wr(A_CTRL, cw(0,0,0,0,0,0,0,1));
    wr(A_CMP, 0);
    wr(A_CTRL, cw(1,0,0,0,0,0,0,0));
    @(negedge clk); time_tick = 1'b1;
    wr(A_CTRL, cw(1,0,0,0,0,0,0,1));
    time_tick = 1'b0;
    rd(A_CTRL, v); check("R6 set wins over clear", v[8], 1);
    wr(A_CTRL, cw(1,0,0,0,0,0,0,1));
    rd(A_CTRL, v); check("R6 clear works", v[8], 0);

    // R7: disable forces zero and stops counting
    wr(A_CTRL, cw(0,0,0,0,0,0,0,1));
    wr(A_CMP, 100);
    wr(A_CTRL, cw(1,0,0,0,0,0,0,0));
    ticks(3);
    wr(A_CTRL, cw(0,0,0,0,0,0,0,0));
    rd_count(v); check("R7 stop forces zero", v, 0);
    ticks(2);
    rd_count(v); check("R7 no count while stopped", v, 0);
    wr(A_CTRL, cw(1,0,0,0,0,0,0,0));
    ticks(1);
    rd_count(v); check("R7 restart counts from zero", v, 1);

    // R11: snapshot holds until next latch write, read data one cycle later
    ticks(3);
    wr(A_CNT, 0);
    ticks(2);
    rd(A_CNT, v); check("R11 snapshot held", v, 4);
    rd_count(v); check("R11 new snapshot", v, 6);
    rd(A_CMP, v); check("R11 compare readback", v, 100);

    // R9: source fields locked while running
    wr(A_CTRL, cw(1,1,0,1,3,0,0,0));
    rd(A_CTRL, v); check("R9 locked while running", v[7:0], cw(1,0,0,0,0,0,0,0));
    wr(A_CTRL, cw(0,1,0,1,3,0,0,0));
    rd(A_CTRL, v); check("R9 stop write keeps fields", v[7:0], 0);
    wr(A_CTRL, cw(0,1,0,1,2,0,0,0));
    rd(A_CTRL, v); check("R9 accepted while stopped", v[7:0], cw(0,1,0,1,2,0,0,0));

    // R8: pulse mode over every input and polarity
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 2; p++) begin
        wr(A_CTRL, cw(0,0,0,0,0,0,0,1));
        wr(A_CMP, 16'hFFFF);
        pulse_in = p[0] ? 4'hF : 4'h0;
        wr(A_CTRL, cw(0,1,0,p[0],s[1:0],0,0,0));
        wr(A_CTRL, cw(1,1,0,p[0],s[1:0],0,0,0));
        for (int k = 0; k < 3; k++) pulse(s);
        for (int o = 0; o < 4; o++) if (o != s) pulse(o);
        ticks(2);
        rd_count(v); check("R8 selected edges only", v, 3);
      end
    end
    wr(A_CTRL, cw(0,0,0,0,0,0,0,1));
    pulse_in = 4'h1;
    wr(A_CTRL, cw(0,1,0,0,0,0,0,0));
    wr(A_CTRL, cw(1,1,0,0,0,0,0,0));
    repeat (3) @(negedge clk);
    rd_count(v); check("R8 active at start not counted", v, 0);
    @(negedge clk); pulse_in = 4'h0;
    @(negedge clk); pulse_in = 4'h1;
    rd_count(v); check("R8 later edge counted", v, 1);
    pulse_in = 4'h0;

    // R10: DMA request gating
    wr(A_CTRL, cw(0,0,0,0,0,0,0,1));
    wr(A_CMP, 1);
    wr(A_CTRL, cw(1,0,0,0,0,0,1,0));
    ticks(2);
    check("R10 dma set", {31'd0, dma_req}, 1);
    check("R10 irq masked", {31'd0, irq}, 0);
    wr(A_CTRL, cw(1,0,0,0,0,0,1,1));
    check("R10 dma cleared", {31'd0, dma_req}, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule